// File: doc/BRIEF.md
# Instruction Fetch Stage with Static Backward-Taken Prediction

This block is the front of an out-of-order core. It holds the program counter, presents it to an instruction memory whose read data returns in the same cycle, and latches the fetched word together with its address into a single-entry fetch buffer. The enqueue stage reads that buffer and can hold it with a stall input.

Conditional branches are predicted statically. A branch with a negative offset (a loop back-edge) is predicted taken. Its target is formed while the branch waits in the fetch buffer and is written into the program counter. The word fetched in that same cycle is dropped, so a predicted-taken branch costs exactly one bubble. A branch with a non-negative offset is predicted not-taken and flows on like any other instruction. It still reaches the functional units, which check it. When that check finds a misprediction, the functional unit drives a correction address. The correction wins over every other source of the next program counter and empties the fetch buffer.

Top module: `fetch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the program counter equals RESET_PC (default 0) and the fetch buffer is empty (`fb_valid` low).
- R2: `imem_addr` always equals the current program counter.
- R3: With no stall, no correction and no predicted-taken branch in the buffer, a clock edge loads `imem_rdata` and the current program counter into the buffer, sets `fb_valid`, and advances the program counter by one (modulo 2^PC_W).
- R4: An instruction is a conditional branch when bits [15:13] equal 3'b110. Its offset is bits [6:0], read as a two's-complement value.
- R5: A conditional branch whose offset is zero or positive is handled as in R3, with no bubble.
- R6: When the valid buffer holds a conditional branch with a negative offset and there is no stall and no correction, the next edge sets the program counter to branch address + 1 + sign-extended offset and clears `fb_valid`. The word at the target enters the buffer on the edge after that.
- R7: While `enq_stall` is high and `redir_valid` is low, the program counter and every fetch-buffer output stay unchanged.
- R8: When `redir_valid` is high, the next edge sets the program counter to `redir_pc` and clears `fb_valid`. This happens even during a stall and even when a predicted-taken branch sits in the buffer.
- R9: A word whose bits [15:13] differ from 3'b110 never redirects, even when bit 6 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Address sent to instruction memory |
| imem_rdata | input | INSTR_W | Instruction word read back in the same cycle |
| enq_stall | input | 1 | Enqueue stage cannot accept; hold state |
| redir_valid | input | 1 | Misprediction correction from the functional units |
| redir_pc | input | PC_W | Corrected fetch address |
| fb_valid | output | 1 | Fetch buffer holds an instruction |
| fb_pc | output | PC_W | Address of the buffered instruction |
| fb_instr | output | INSTR_W | Buffered instruction word |

## Verification
The interesting collision is a misprediction correction that arrives in the same cycle the prediction logic wants to redirect toward a backward branch target. The bench provokes it by watching its own model. When the model shows a taken branch sitting in the buffer, the bench raises `redir_valid` for that edge. It then judges that the program counter follows `redir_pc` and not the predicted target. A correction arriving during a stall is provoked too, and it must break the hold.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
   typedef enum logic [1:0] {
      NPC_SEQ  = 2'd0,
      NPC_HOLD = 2'd1,
      NPC_PRED = 2'd2,
      NPC_FIX  = 2'd3
   } npc_src_e;
endpackage

// File: rtl/fetch_predict.sv
module fetch_predict #(
   parameter int PC_W    = 8,
   parameter int INSTR_W = 16,
   parameter int OP_W    = 3,
   parameter int OFF_W   = 7,
   parameter logic [OP_W-1:0] BR_OP = 3'b110
) (
   input  logic               buf_ok,
   input  logic [INSTR_W-1:0] buf_word,
   input  logic [PC_W-1:0]    buf_addr,
   output logic               go_back,
   output logic [PC_W-1:0]    back_tgt
);
   localparam int OP_LSB = INSTR_W - OP_W;

   logic [OFF_W-1:0] disp;
   logic [PC_W-1:0]  disp_ext;
   logic             is_br;

   assign disp  = buf_word[OFF_W-1:0];
   assign is_br = (buf_word[INSTR_W-1:OP_LSB] == BR_OP);

   generate
      if (OFF_W < PC_W) begin : g_widen
         assign disp_ext = {{(PC_W-OFF_W){disp[OFF_W-1]}}, disp};
      end else begin : g_trim
         assign disp_ext = disp[PC_W-1:0];
      end
   endgenerate

   assign go_back  = buf_ok && is_br && disp[OFF_W-1];
   assign back_tgt = buf_addr + PC_W'(1) + disp_ext;
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
   import fetch_pkg::*;
#(
   parameter int PC_W = 8,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  npc_src_e        src,
   input  logic [PC_W-1:0] pred_tgt,
   input  logic [PC_W-1:0] fix_tgt,
   output logic [PC_W-1:0] pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= RESET_PC;
      end else begin
         unique case (src)
            NPC_SEQ:  pc <= pc + PC_W'(1);
            NPC_HOLD: pc <= pc;
            NPC_PRED: pc <= pred_tgt;
            NPC_FIX:  pc <= fix_tgt;
            default:  pc <= pc;
         endcase
      end
   end
endmodule

// File: rtl/fetch_buf.sv
module fetch_buf
   import fetch_pkg::*;
#(
   parameter int PC_W    = 8,
   parameter int INSTR_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  npc_src_e           src,
   input  logic [PC_W-1:0]    in_addr,
   input  logic [INSTR_W-1:0] in_word,
   output logic               out_ok,
   output logic [PC_W-1:0]    out_addr,
   output logic [INSTR_W-1:0] out_word
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_ok   <= 1'b0;
         out_addr <= '0;
         out_word <= '0;
      end else begin
         case (src)
            NPC_SEQ: begin
               out_ok   <= 1'b1;
               out_addr <= in_addr;
               out_word <= in_word;
            end
            NPC_PRED, NPC_FIX: out_ok <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
   import fetch_pkg::*;
#(
   parameter int PC_W    = 8,
   parameter int INSTR_W = 16,
   parameter int OP_W    = 3,
   parameter int OFF_W   = 7,
   parameter logic [OP_W-1:0] BR_OP    = 3'b110,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_rdata,
   input  logic               enq_stall,
   input  logic               redir_valid,
   input  logic [PC_W-1:0]    redir_pc,
   output logic               fb_valid,
   output logic [PC_W-1:0]    fb_pc,
   output logic [INSTR_W-1:0] fb_instr
);
   initial begin
      if (PC_W < 2) $error("PC_W must be at least 2");
      if (OP_W + OFF_W > INSTR_W) $error("opcode and offset overlap");
      if (OFF_W < 2) $error("OFF_W must be at least 2");
   end

   npc_src_e        src;
   logic [PC_W-1:0] pc_q;
   logic            pred_take;
   logic [PC_W-1:0] pred_tgt;

   fetch_predict #(.PC_W(PC_W), .INSTR_W(INSTR_W), .OP_W(OP_W), .OFF_W(OFF_W), .BR_OP(BR_OP)) u_pred (
      .buf_ok(fb_valid), .buf_word(fb_instr), .buf_addr(fb_pc),
      .go_back(pred_take), .back_tgt(pred_tgt)
   );

   always_comb begin
      if (redir_valid)    src = NPC_FIX;
      else if (enq_stall) src = NPC_HOLD;
      else if (pred_take) src = NPC_PRED;
      else                src = NPC_SEQ;
   end

   fetch_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
      .clk(clk), .rst_n(rst_n), .src(src),
      .pred_tgt(pred_tgt), .fix_tgt(redir_pc), .pc(pc_q)
   );

   fetch_buf #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .src(src),
      .in_addr(pc_q), .in_word(imem_rdata),
      .out_ok(fb_valid), .out_addr(fb_pc), .out_word(fb_instr)
   );

   assign imem_addr = pc_q;

   // R1: state right after reset
   a_r1_reset_empty: assert property (@(posedge clk) $fell(rst_n) |=> !fb_valid && pc_q == RESET_PC);

   // R3: sequential fetch latches the word and advances
   a_r3_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_valid && !enq_stall && !pred_take) |=>
      fb_valid && fb_pc == $past(pc_q) && fb_instr == $past(imem_rdata) && pc_q == $past(pc_q) + PC_W'(1));

   // R6: predicted-taken branch costs one bubble
   a_r6_pred_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir_valid && !enq_stall && pred_take) |=> !fb_valid && pc_q == $past(pred_tgt));

   // R7: stall freezes everything
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_stall && !redir_valid) |=>
      $stable(pc_q) && $stable(fb_valid) && $stable(fb_pc) && $stable(fb_instr));

   // R8: correction wins
   a_r8_fix_wins: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !fb_valid && pc_q == $past(redir_pc));
endmodule

// File: tb/sim_fetch_unit.sv
module sim_fetch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  imem_addr;
   logic [15:0] imem_rdata;
   logic        enq_stall = 1'b0;
   logic        redir_valid = 1'b0;
   logic [7:0]  redir_pc = '0;
   logic        fb_valid;
   logic [7:0]  fb_pc;
   logic [15:0] fb_instr;

   int checks = 0, errors = 0, cyc = 0, taken_seen = 0, collided = 0;
   int m_pc = 0, m_fbpc = 0, m_fbi = 0;
   bit m_fbv = 0;
   string tag = "R1";

   always #2 clk = ~clk;

   function automatic logic [15:0] mem(input int a);
      if (a == 20) return {3'b110, 6'b0, 7'b1111011}; // back -5 -> 16
      if (a == 5)  return {3'b110, 6'b0, 7'b0000011}; // forward +3
      if (a == 6)  return {3'b010, 6'b0, 7'b1110000}; // not a branch, bit6 set
      return 16'h0100 | 16'(a);
   endfunction

   function automatic bit is_taken(input int w);
      return (w[15:13] == 3'b110) && w[6];
   endfunction

   assign imem_rdata = mem(int'(imem_addr));

   fetch_unit u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .enq_stall(enq_stall), .redir_valid(redir_valid), .redir_pc(redir_pc),
      .fb_valid(fb_valid), .fb_pc(fb_pc), .fb_instr(fb_instr)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference, advanced on every edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_fbv = 0; tag = "R1";
      end else if (redir_valid) begin
         m_pc = int'(redir_pc); m_fbv = 0; tag = "R8";
      end else if (enq_stall) begin
         tag = "R7";
      end else if (m_fbv && is_taken(m_fbi)) begin
         m_pc = (m_fbpc + 1 + (m_fbi[6] ? m_fbi[6:0] - 128 : m_fbi[6:0])) & 255;
         m_fbv = 0; tag = "R4 R6"; taken_seen++;
      end else begin
         if (m_fbv && m_fbi[15:13] == 3'b110) tag = "R5";
         else if (m_fbv && m_fbi[6]) tag = "R9";
         else tag = "R3";
         m_fbpc = m_pc; m_fbi = int'(mem(m_pc)); m_fbv = 1;
         m_pc = (m_pc + 1) & 255;
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", int'(fb_valid), 0, "fb_valid in reset");
      chk("R1", int'(imem_addr), 0, "pc in reset");
      rst_n = 1'b1;
      for (int n = 0; n < 170; n++) begin
         @(negedge clk);
         cyc++;
         chk("R2", int'(imem_addr), m_pc, "imem_addr");
         chk(tag, int'(fb_valid), int'(m_fbv), "fb_valid");
         if (m_fbv) begin
            chk(tag, int'(fb_pc), m_fbpc, "fb_pc");
            chk(tag, int'(fb_instr), m_fbi, "fb_instr");
         end
         enq_stall   = (cyc % 9 == 4) || (cyc >= 60 && cyc <= 62);
         redir_valid = 1'b0;
         if (cyc == 40) begin redir_valid = 1'b1; redir_pc = 8'd30; end
         if (cyc == 61) begin redir_valid = 1'b1; redir_pc = 8'd5; end
         if (cyc == 120) begin redir_valid = 1'b1; redir_pc = 8'd18; end
         if (collided == 0 && cyc > 80 && !enq_stall && m_fbv && is_taken(m_fbi)) begin
            redir_valid = 1'b1; redir_pc = 8'd100; collided++;
         end
      end
      chk("R8", collided, 1, "correction met a taken prediction");
      chk("R6", int'(taken_seen > 2), 1, "taken branches seen");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule